// File: doc/BRIEF.md
# Flash Program Interlock Sequencer

This block is the control state machine that stands between a bus and the programming machinery of a non-volatile memory array. It makes software pass through an interlock before high voltage can be applied: a control-register write arms a programming session, a real write to the array must follow, and only then may the high-voltage enable bit be set. Each of the four states decides whether array reads are served normally, served as margin reads or refused, and which control fields a register write may change.

The bus port carries one access per cycle: read or write, an array-versus-register select, an address and write data. A register write always targets the single control register, whose fields are session enable (bit 0), program select (bit 1, 0 = program), high-voltage enable (bit 2) and a 3-bit clock-scale field (bits 6:4); bits 3 and 7 always read 0. When the program state is entered with a nonzero clock scale, a pulse timer counts scale × 2^PULSE_SHIFT cycles and a busy status shows software when the pulse has run its course. Array writes that are accepted produce a strobe that carries address and data toward the page buffer.

Top module: `nvm_prog_guard`

## Requirements
- R1: While the master reset `rst` is high on a clock edge, the state code becomes 0 (normal) and the control register becomes 0, so `hv_req` and `hv_busy` are 0.
- R2: In normal (code 0), a register write stores the data with high-voltage enable forced to 0, and moves to first-interlock (code 1) when bit 1 is 0 and bit 0 is 1; any other register write leaves the state at 0.
- R3: In first-interlock, a register write with bit 0 = 0 returns to normal; other register writes stay in code 1, store no page-buffer data, and cannot set high-voltage enable.
- R4: In first-interlock, an array read gives `arr_resp`=1 and `margin_rd`=0; an array write raises `pb_strobe` in its own cycle and moves to expanded-interlock (code 2).
- R5: In expanded-interlock, an array read gives `arr_resp`=1 and `margin_rd`=1; an array write raises `pb_strobe` and the state stays at code 2.
- R6: In expanded-interlock, a register write with bit 0 = 0 returns to normal with high-voltage enable cleared; otherwise a write with bit 2 = 1 moves to program (code 3).
- R7: In program, an array read or write gives `bus_err`=1 in that cycle with `arr_resp`=0 and `pb_strobe`=0; a register write changes only bit 2 of the control register.
- R8: In program, a register write with bit 2 = 0, or `map_off` or `soft_rst` high, moves to expanded-interlock with high-voltage enable cleared; `map_off` or `soft_rst` wins over a register write in the same cycle.
- R9: A master reset returns the block to normal from every state, including program.
- R10: `hv_req` is 1 exactly while in program. With a nonzero clock scale S, `hv_busy` is 1 for the first S × 2^PULSE_SHIFT cycles in program and then 0; with S = 0 it stays 1 for the whole stay. The scale used is the one held on entry, including one written by the entering write.
- R11: In normal, an array read gives `arr_resp`=1 and an array write is refused (`pb_strobe`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset; leaves the program state |
| map_off | input | 1 | Memory-map disable; leaves the program state |
| bus_rd | input | 1 | Read access this cycle |
| bus_wr | input | 1 | Write access this cycle |
| bus_arr | input | 1 | 1 = array access, 0 = register access |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | DATA_W | Write data |
| st_code | output | 2 | State: 0 normal, 1 first-interlock, 2 expanded-interlock, 3 program |
| ctl_q | output | 8 | Control register contents |
| arr_resp | output | 1 | Array serves the current read |
| margin_rd | output | 1 | Current array read is a margin read |
| pb_strobe | output | 1 | Array write accepted into the page buffer |
| pb_addr | output | ADDR_W | Page-buffer write address |
| pb_data | output | DATA_W | Page-buffer write data |
| bus_err | output | 1 | Array access refused during program |
| hv_req | output | 1 | High-voltage request |
| hv_busy | output | 1 | Programming pulse still running |

## Verification
The collision that matters is an exit request landing in the same cycle as a register write inside the program state: `soft_rst` or `map_off` is raised together with a write that keeps bit 2 at 1, and the block must still drop to expanded-interlock with high-voltage enable cleared. A second overlap is the pulse timer expiring in the same cycle that software clears high-voltage enable. Both are provoked in directed steps and again by random traffic that raises the exit inputs at a low rate, and every cycle's state code, control register, strobes and busy flag are compared with a bench model built from the requirements.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_EXP  = 2'd2,
        ST_PROG = 2'd3
    } pg_state_e;

    typedef struct packed {
        logic       rsv_hi;
        logic [2:0] scale;
        logic       rsv_lo;
        logic       hv_en;
        logic       prog_sel;
        logic       sess_en;
    } pg_ctl_t;

    // How a cycle may change the control register
    typedef enum logic [2:0] {
        CW_NONE,
        CW_IDLE,
        CW_KEEPHV,
        CW_FULL,
        CW_HVONLY,
        CW_DROPHV
    } pg_cw_e;

    function automatic pg_ctl_t to_ctl(input logic [7:0] b);
        pg_ctl_t c;
        c        = pg_ctl_t'(b);
        c.rsv_hi = 1'b0;
        c.rsv_lo = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/nvm_prog_ctlreg.sv
module nvm_prog_ctlreg
    import nvm_prog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pg_cw_e     mode,
    input  pg_ctl_t    wval,
    output pg_ctl_t    ctl_q,
    output logic [2:0] scale_nxt
);
    pg_ctl_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        case (mode)
            CW_IDLE: begin
                ctl_d       = wval;
                ctl_d.hv_en = 1'b0;
            end
            CW_KEEPHV: begin
                ctl_d       = wval;
                ctl_d.hv_en = ctl_q.hv_en;
            end
            CW_FULL: begin
                ctl_d       = wval;
                ctl_d.hv_en = wval.hv_en & wval.sess_en;
            end
            CW_HVONLY: ctl_d.hv_en = wval.hv_en;
            CW_DROPHV: ctl_d.hv_en = 1'b0;
            default:   ctl_d = ctl_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign scale_nxt = ctl_d.scale;

    // R7: a write in program mode may alter only the high-voltage bit
    p_hvonly_keeps_rest_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == CW_HVONLY) |=> (ctl_q.scale == $past(ctl_q.scale)
                                 && ctl_q.sess_en == $past(ctl_q.sess_en)
                                 && ctl_q.prog_sel == $past(ctl_q.prog_sel)));

endmodule

// File: rtl/nvm_prog_fsm.sv
module nvm_prog_fsm
    import nvm_prog_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      reg_wr,
    input  logic      arr_wr,
    input  logic      exit_req,
    input  logic      w_se,
    input  logic      w_ps,
    input  logic      w_hv,
    output pg_state_e state_q,
    output pg_cw_e    mode
);
    pg_state_e state_d;

    always_comb begin
        state_d = state_q;
        mode    = CW_NONE;
        case (state_q)
            ST_IDLE: if (reg_wr) begin
                mode = CW_IDLE;
                if (!w_ps && w_se) state_d = ST_ARM;
            end
            ST_ARM: if (reg_wr) begin
                mode = CW_KEEPHV;
                if (!w_se) state_d = ST_IDLE;
            end else if (arr_wr) begin
                state_d = ST_EXP;
            end
            ST_EXP: if (reg_wr) begin
                mode = CW_FULL;
                if (!w_se)     state_d = ST_IDLE;
                else if (w_hv) state_d = ST_PROG;
            end
            ST_PROG: if (exit_req) begin
                mode    = CW_DROPHV;
                state_d = ST_EXP;
            end else if (reg_wr) begin
                mode = CW_HVONLY;
                if (!w_hv) state_d = ST_EXP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // R4: expanded-interlock is reached only after first-interlock (or back from program)
    p_exp_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXP && $past(state_q) != ST_EXP)
            |-> ($past(state_q) == ST_ARM || $past(state_q) == ST_PROG));

    // R6: program is entered only from expanded-interlock
    p_prog_entry_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROG && $past(state_q) != ST_PROG) |-> $past(state_q) == ST_EXP);

    // R9: the cycle after a master reset finds the block in normal
    p_master_rst_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> state_q == ST_IDLE);

    // R8: an exit request in program lands in expanded-interlock
    p_exit_prog_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROG && exit_req) |=> state_q == ST_EXP);

endmodule

// File: rtl/nvm_prog_pulse.sv
module nvm_prog_pulse #(
    parameter int PULSE_SHIFT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_prog,
    input  logic [2:0] scale_nxt,
    input  logic [2:0] scale_cur,
    output logic       hv_busy
);
    localparam int CW = 3 + PULSE_SHIFT;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (!in_prog)    cnt <= CW'(scale_nxt) << PULSE_SHIFT;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign hv_busy = in_prog && (scale_cur == 3'd0 || cnt != '0);

    // R10: once the pulse has ended it stays ended for the rest of the stay
    p_busy_stays_low_r10: assert property (@(posedge clk) disable iff (rst)
        (in_prog && $past(in_prog) && !$past(hv_busy)) |-> !hv_busy);

endmodule

// File: rtl/nvm_prog_guard.sv
module nvm_prog_guard
    import nvm_prog_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int PULSE_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              map_off,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_arr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [1:0]        st_code,
    output logic [7:0]        ctl_q,
    output logic              arr_resp,
    output logic              margin_rd,
    output logic              pb_strobe,
    output logic [ADDR_W-1:0] pb_addr,
    output logic [DATA_W-1:0] pb_data,
    output logic              bus_err,
    output logic              hv_req,
    output logic              hv_busy
);
    pg_state_e  state;
    pg_cw_e     mode;
    pg_ctl_t    wval;
    pg_ctl_t    ctl;
    logic [2:0] scale_nxt;
    logic       in_prog;
    logic       reg_wr;
    logic       arr_wr;

    assign wval    = to_ctl(bus_wdata[7:0]);
    assign reg_wr  = bus_wr && !bus_arr;
    assign arr_wr  = bus_wr && bus_arr;
    assign in_prog = (state == ST_PROG);

    nvm_prog_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .arr_wr   (arr_wr),
        .exit_req (soft_rst || map_off),
        .w_se     (wval.sess_en),
        .w_ps     (wval.prog_sel),
        .w_hv     (wval.hv_en),
        .state_q  (state),
        .mode     (mode)
    );

    nvm_prog_ctlreg u_ctl (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .wval      (wval),
        .ctl_q     (ctl),
        .scale_nxt (scale_nxt)
    );

    nvm_prog_pulse #(.PULSE_SHIFT(PULSE_SHIFT)) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .in_prog   (in_prog),
        .scale_nxt (scale_nxt),
        .scale_cur (ctl.scale),
        .hv_busy   (hv_busy)
    );

    assign st_code   = state;
    assign ctl_q     = ctl;
    assign arr_resp  = bus_rd && bus_arr && !in_prog;
    assign margin_rd = bus_rd && bus_arr && (state == ST_EXP);
    assign pb_strobe = arr_wr && (state == ST_ARM || state == ST_EXP);
    assign pb_addr   = bus_addr;
    assign pb_data   = bus_wdata;
    assign bus_err   = bus_arr && (bus_rd || bus_wr) && in_prog;
    assign hv_req    = in_prog;

    // R3: high voltage cannot be enabled before the interlock write
    p_arm_hv_low_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_ARM) |-> !ctl.hv_en);

    // R7: the array stays silent while programming
    p_prog_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        in_prog |-> (!arr_resp && !pb_strobe && !margin_rd));

    // R6: the program state always holds the high-voltage bit set
    p_prog_hv_set_r6: assert property (@(posedge clk) disable iff (rst)
        in_prog |-> ctl.hv_en);

endmodule

// File: tb/nvm_prog_guard_bench.sv
module nvm_prog_guard_bench;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SH = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          soft_rst = 1'b0, map_off = 1'b0;
    logic          bus_rd = 1'b0, bus_wr = 1'b0, bus_arr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [1:0]    st_code;
    logic [7:0]    ctl_q;
    logic          arr_resp, margin_rd, pb_strobe, bus_err, hv_req, hv_busy;
    logic [AW-1:0] pb_addr;
    logic [DW-1:0] pb_data;

    int total = 0;
    int bad = 0;
    int m_st = 0;
    logic [7:0] m_ctl = 8'h00;
    int m_cnt = 0;

    always #4 clk = ~clk;

    nvm_prog_guard #(.ADDR_W(AW), .DATA_W(DW), .PULSE_SHIFT(SH)) u_nvm_prog_guard (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .map_off(map_off),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_arr(bus_arr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .st_code(st_code), .ctl_q(ctl_q), .arr_resp(arr_resp),
        .margin_rd(margin_rd), .pb_strobe(pb_strobe), .pb_addr(pb_addr),
        .pb_data(pb_data), .bus_err(bus_err), .hv_req(hv_req), .hv_busy(hv_busy)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int st);
        case (st)
            0: return "R11";
            1: return "R4";
            2: return "R5";
            default: return "R7";
        endcase
    endfunction

    // Registered outputs versus the model, sampled at the falling edge
    task automatic chk_regs(input string tag);
        chk(tag, "st_code", int'(st_code), m_st);
        chk(tag, "ctl_q", int'(ctl_q), int'(m_ctl));
        chk("R10", "hv_req", int'(hv_req), int'(m_st == 3));
        chk("R10", "hv_busy", int'(hv_busy),
            int'(m_st == 3 && (m_ctl[6:4] == 3'd0 || m_cnt != 0)));
    endtask

    // One bus cycle: check state, drive, check combinational outputs, advance model
    task automatic cyc(input string tag, input logic r, input logic rd, input logic wr,
                       input logic arr, input logic [7:0] d, input logic sr, input logic mo);
        logic [7:0] w, nctl;
        int nst;
        @(negedge clk);
        chk_regs(tag);
        rst = r; bus_rd = rd; bus_wr = wr; bus_arr = arr; soft_rst = sr; map_off = mo;
        bus_addr = AW'($urandom); bus_wdata = {DW'($urandom) >> 8, d};
        #1;
        chk(tag, "arr_resp", int'(arr_resp), int'(rd && arr && m_st != 3));
        chk(tag, "margin_rd", int'(margin_rd), int'(rd && arr && m_st == 2));
        chk(tag, "pb_strobe", int'(pb_strobe), int'(wr && arr && (m_st == 1 || m_st == 2)));
        chk(tag, "bus_err", int'(bus_err), int'(arr && (rd || wr) && m_st == 3));
        if (pb_strobe) chk(tag, "pb_data", int'(pb_data[7:0]), int'(d));
        w = d & 8'h77;
        nctl = m_ctl;
        nst = m_st;
        if (r) begin
            nst = 0; nctl = 8'h00;
        end else begin
            case (m_st)
                0: if (wr && !arr) begin
                    nctl = w & 8'hFB;
                    if (!w[1] && w[0]) nst = 1;
                end
                1: if (wr && !arr) begin
                    nctl = (w & 8'hFB) | (m_ctl & 8'h04);
                    if (!w[0]) nst = 0;
                end else if (wr && arr) nst = 2;
                2: if (wr && !arr) begin
                    nctl = w;
                    if (!w[0]) begin nctl[2] = 1'b0; nst = 0; end
                    else if (w[2]) nst = 3;
                end
                default: if (sr || mo) begin
                    nctl[2] = 1'b0; nst = 2;
                end else if (wr && !arr) begin
                    nctl[2] = w[2];
                    if (!w[2]) nst = 2;
                end
            endcase
        end
        if (r) m_cnt = 0;
        else if (m_st != 3) m_cnt = int'(nctl[6:4]) << SH;
        else if (m_cnt > 0) m_cnt--;
        m_st = nst;
        m_ctl = nctl;
    endtask

    task automatic regw(input string tag, input logic [7:0] d);
        cyc(tag, 0, 0, 1, 0, d, 0, 0);
    endtask
    task automatic arrw(input string tag);
        cyc(tag, 0, 0, 1, 1, 8'hA5, 0, 0);
    endtask
    task automatic arrr(input string tag);
        cyc(tag, 0, 1, 0, 1, 8'h00, 0, 0);
    endtask
    task automatic idle(input string tag);
        cyc(tag, 0, 0, 0, 0, 8'h00, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        // R1: reset state
        cyc("R1", 1, 0, 0, 0, 8'h00, 0, 0);
        cyc("R1", 1, 0, 0, 0, 8'h00, 0, 0);
        cyc("R1", 1, 0, 0, 0, 8'h00, 0, 0);
        idle("R1");
        // R11: normal refuses array writes, serves reads
        arrw("R11");
        arrr("R11");
        // R2: hv bit dropped, session armed
        regw("R2", 8'h15);
        regw("R2", 8'h17);   // program select 1 in first-interlock keeps code 1
        // R3: hv held low, session drop returns to normal
        regw("R3", 8'h15);
        regw("R3", 8'h10);
        regw("R2", 8'h13);   // program select 1: stays normal
        regw("R2", 8'h11);
        // R4: reads normal, array write advances
        arrr("R4");
        arrw("R4");
        // R5: margin read, more writes accepted
        arrr("R5");
        arrw("R5");
        // R6: session drop wins over hv=1
        regw("R6", 8'h14);
        regw("R6", 8'h11);
        arrw("R6");
        regw("R6", 8'h15);   // enter program, scale 1 -> 4 busy cycles
        // R7: array refused, only hv bit writable
        arrr("R7");
        arrw("R7");
        regw("R7", 8'h75);
        for (int i = 0; i < 4; i++) idle("R10");
        // R8: clearing hv leaves programming
        regw("R8", 8'h11);
        regw("R10", 8'h05);  // scale 0: busy stays high
        for (int i = 0; i < 12; i++) idle("R10");
        cyc("R8", 0, 0, 0, 0, 8'h00, 0, 1);          // memory-map disable
        regw("R10", 8'h25);                          // scale 2
        for (int i = 0; i < 7; i++) idle("R10");
        regw("R8", 8'h21);                           // hv cleared as pulse ends
        regw("R8", 8'h15);
        cyc("R8", 0, 0, 1, 0, 8'h15, 1, 0);          // soft reset beats hv=1 write
        regw("R8", 8'h15);
        // R9: master reset from program
        cyc("R9", 1, 0, 0, 0, 8'h00, 0, 0);
        idle("R9");
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [7:0] d;
            logic r, sr, mo;
            op = int'($urandom % 8);
            case ($urandom % 4)
                0: d = 8'(($urandom % 8) << 4) | 8'h05;
                1: d = 8'h11;
                2: d = 8'h01;
                default: d = 8'($urandom);
            endcase
            r  = ($urandom % 300) == 0;
            sr = ($urandom % 24) == 0;
            mo = ($urandom % 24) == 0;
            case (op)
                0, 1: cyc(tag_of(m_st), r, 0, 1, 0, d, sr, mo);
                2, 3: cyc(tag_of(m_st), r, 0, 1, 1, d, sr, mo);
                4, 5: cyc(tag_of(m_st), r, 1, 0, 1, d, sr, mo);
                6:    cyc(tag_of(m_st), r, 1, 0, 0, d, sr, mo);
                default: cyc(tag_of(m_st), r, 0, 0, 0, d, sr, mo);
            endcase
        end
        idle("R1");
        @(negedge clk);
        chk_regs("R1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule